// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Fixed-Latency Refill

This block sits between a processor port and a word-wide memory port and keeps one 32-bit word per line in a direct-mapped array of lines (1024 by default). A processor read picks its line from the word address modulo the line count. It hits when that line is valid and holds the same upper address bits. A hit answers in the cycle of the request. A read miss holds the processor off for a fixed refill window and then completes as an ordinary lookup of the freshly installed line.

The refill window follows a fixed memory timing: one cycle to issue the address, a DRAM access period (25 cycles by default) and one cycle in which the word is taken from the memory bus. That makes 27 stall cycles per miss. Writes go straight through to memory in one cycle. They refresh the stored word only when they hit and never claim a line. Two counters record read hits and read misses, so hit rates over reference strings can be measured from outside.

Top module: `dm_cache`

## Requirements
- R1: The byte address is split as byte offset in bits 1..0, line index in bits 11..2 (10 bits) and tag in bits 31..12 (20 bits), scaled by the INDEX_W parameter.
- R2: While and after reset every line is invalid and both counters read zero, so the first read of any block misses.
- R3: A read hits when the indexed line is valid and its stored tag equals the address tag; cpu_ready is then high in the request cycle and cpu_rdata carries the stored word.
- R4: A read miss holds cpu_ready low for exactly SEND_CYC+DRAM_CYC+RET_CYC cycles (27 by default), raises mem_rd for a single cycle at the start with mem_addr equal to cpu_addr, and returns the memory word in the cycle after the last stall cycle.
- R5: A line whose index matches but whose tag differs is always replaced on a read miss, so two such addresses read alternately miss every time (word addresses 0 and 4 with 4 lines).
- R6: A write completes in its own cycle with mem_we high and mem_addr, mem_wdata equal to the processor values; a write hit replaces the stored word, and a write miss leaves the cache contents unchanged (no allocation).
- R7: hit_count increases by one for each read that hits at request time; miss_count increases by one for each read miss; the completion cycle after a refill counts as neither.
- R8: The byte offset plays no part in the lookup: any of the four byte addresses of a cached word hits and returns that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, invalidates all lines |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, held stable while stalled |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when cpu_ready is high on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_rd | output | 1 | One-cycle refill request |
| mem_we | output | 1 | Write-through strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-through data |
| mem_rdata | input | 32 | Memory word, taken in the last stall cycle |
| hit_count | output | CNT_W | Read hit counter |
| miss_count | output | CNT_W | Read miss counter |

## Verification
The bench builds the cache with INDEX_W=2, so only four lines exist and a 16-word address range already produces every tag and index pairing, while the default DRAM_CYC keeps the full 27-cycle stall under test. With so few lines the classic reference strings evict and re-hit in a handful of accesses, and a sweep of every word in the range reaches each line under four different tags. Reset during a filled state and write hits and misses on aliased lines are reachable in a few dozen cycles.

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int OFF_W    = 2,
  parameter int INDEX_W  = 10,
  parameter int SEND_CYC = 1,
  parameter int DRAM_CYC = 25,
  parameter int RET_CYC  = 1,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;
  localparam int STALL = SEND_CYC + DRAM_CYC + RET_CYC;
  localparam int CW    = $clog2(STALL + 1);

  logic [LINES-1:0]   valid_q;
  logic [TAG_W-1:0]   tag_q  [LINES];
  logic [DATA_W-1:0]  data_q [LINES];
  logic               busy_q, filled_q;
  logic [CW-1:0]      cnt_q;

  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   tg;
  logic               hit, rd_req, wr_req, last;

  assign idx    = cpu_addr[OFF_W +: INDEX_W];
  assign tg     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign hit    = valid_q[idx] && (tag_q[idx] == tg);
  assign rd_req = cpu_req && !cpu_we;
  assign wr_req = cpu_req && cpu_we && !busy_q;
  assign last   = busy_q && (cnt_q == CW'(STALL - 1));

  assign cpu_ready = !busy_q && (!cpu_req || cpu_we || hit);
  assign cpu_rdata = data_q[idx];
  assign mem_rd    = rd_req && !busy_q && !hit;
  assign mem_we    = wr_req;
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      busy_q     <= 1'b0;
      filled_q   <= 1'b0;
      cnt_q      <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      filled_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q       <= 1'b0;
          filled_q     <= 1'b1;
          valid_q[idx] <= 1'b1;
          cnt_q        <= '0;
        end
      end else if (mem_rd) begin
        busy_q     <= 1'b1;
        cnt_q      <= CW'(1);
        miss_count <= miss_count + 1'b1;
      end else if (rd_req && hit && !filled_q) begin
        hit_count <= hit_count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (last) begin
      tag_q[idx]  <= tg;
      data_q[idx] <= mem_rdata;
    end else if (wr_req && hit) begin
      data_q[idx] <= cpu_wdata;
    end
  end
endmodule

module dm_cache_chk #(
  parameter int STALL = 27,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             cpu_ready,
  input logic             mem_rd,
  input logic             mem_we,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  localparam int CW = $clog2(STALL + 1);
  logic [CW-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) win <= '0;
    else if (mem_rd) win <= CW'(1);
    else if (win != '0 && win < CW'(STALL)) win <= win + 1'b1;
    else win <= '0;
  end

  AST_SINGLE_REFILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R4
  AST_STALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0 && win < CW'(STALL)) |-> !cpu_ready); // R4
  AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (win == CW'(STALL) && cpu_req && !cpu_we) |-> cpu_ready); // R4
  AST_HIT_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_ready) |-> !mem_rd); // R3
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ready) |-> mem_we); // R6
  AST_MISS_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> miss_count == $past(miss_count) + 1'b1); // R7
  AST_HIT_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(!rst_n) |-> (hit_count - $past(hit_count)) <= 1); // R7
endmodule

bind dm_cache dm_cache_chk #(.STALL(SEND_CYC + DRAM_CYC + RET_CYC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .mem_rd(mem_rd), .mem_we(mem_we), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/dm_cache_tb.sv
module dm_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STALL      = 27;

  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        cpu_ready, mem_rd, mem_we;
  logic [31:0] hit_count, miss_count;
  logic [31:0] mem [64];
  int checks = 0, fails = 0, nrd = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_cache #(.INDEX_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count));

  assign mem_rdata = mem[mem_addr[7:2]];

  initial for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 + i * 32'h0001_0203;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (rst_n && mem_rd) nrd++;
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output int st, output int pulses);
    int n0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    n0 = nrd; st = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; st++; end
    d = cpu_rdata;
    @(posedge clk); #1;
    pulses = nrd - n0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v, output bit ok);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = v;
    #1;
    ok = cpu_ready && mem_we && mem_addr == a && mem_wdata == v && !mem_rd;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); cpu_req = 0; cpu_we = 0;
  endtask

  // expect a read: miss (27 stall, one pulse) or hit (0 stall, no pulse)
  task automatic expect_rd(input int w, input int off, input bit miss, input string req);
    logic [31:0] d; int st, p;
    rd(w * 4 + off, d, st, p);
    chk(st == (miss ? STALL : 0), req, st, miss ? STALL : 0);
    chk(p == (miss ? 1 : 0), req, p, miss ? 1 : 0);
    chk(d == mem[w], req, d, mem[w]);
  endtask

  initial begin
    logic [31:0] h0, m0;
    bit ok;
    int ref1 [8] = '{0, 1, 2, 3, 4, 3, 4, 14};
    bit exp1 [8] = '{1, 1, 1, 1, 1, 0, 0, 1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    chk(cpu_ready && !mem_rd && !mem_we, "R2 reset outputs", {cpu_ready, mem_rd, mem_we}, 3'b100);
    chk(hit_count == 0 && miss_count == 0, "R2 reset counters", hit_count | miss_count, 0);
    rst_n = 1;

    // R5 R7 reference string 0 1 2 3 4 3 4 14 with four lines
    for (int i = 0; i < 8; i++) expect_rd(ref1[i], 0, exp1[i], "R5 ref string");
    idle();
    chk(miss_count == 6, "R7 misses ref string", miss_count, 6);
    chk(hit_count == 2, "R7 hits ref string", hit_count, 2);

    // R5 ping-pong 0 4 0 4 ...
    h0 = hit_count; m0 = miss_count;
    for (int i = 0; i < 8; i++) expect_rd((i % 2) * 4, 0, 1, "R5 ping-pong");
    idle();
    chk(miss_count - m0 == 8 && hit_count == h0, "R5 ping-pong counts", miss_count - m0, 8);

    // R2 reset invalidation of a filled line
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk(hit_count == 0 && miss_count == 0, "R2 counters cleared", hit_count | miss_count, 0);
    rst_n = 1;
    expect_rd(4, 0, 1, "R2 first read after reset");

    // R1 R3 R8 sweep: every word under every tag, miss then hit then byte-offset hit
    for (int w = 0; w < 16; w++) begin
      expect_rd(w, 0, 1, "R1 sweep first read");
      expect_rd(w, 0, 0, "R3 sweep second read");
      expect_rd(w, w % 4, 0, "R8 offset read");
    end
    idle();
    chk(miss_count == 17, "R7 sweep misses", miss_count, 17);
    chk(hit_count == 32, "R7 sweep hits", hit_count, 32);

    // R6 write hit: word 5 cached (index 1)
    expect_rd(5, 0, 1, "R6 prime line");
    wr(5 * 4, 32'hDEAD_BEEF, ok);
    chk(ok, "R6 write hit through", ok, 1);
    expect_rd(5, 0, 0, "R6 write hit updates");
    chk(cpu_rdata == 32'hDEAD_BEEF, "R6 new word", cpu_rdata, 32'hDEAD_BEEF);
    // R6 write miss: word 9 shares index 1, not allocated; word 5 stays
    wr(9 * 4, 32'h1234_5678, ok);
    chk(ok, "R6 write miss through", ok, 1);
    expect_rd(5, 0, 0, "R6 no allocate keeps line");
    expect_rd(9, 0, 1, "R6 write miss not cached");
    chk(mem[9] == 32'h1234_5678, "R6 memory updated", mem[9], 32'h1234_5678);
    expect_rd(5, 0, 1, "R5 evicted by 9");
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule